// File: doc/BRIEF.md
# Storage Channel Interrupt Status Block

This block gathers interrupt events for one storage channel. There are two event sources. The first is a channel interrupt, which covers transfer completion and device requests. The second is a bus error seen during a DMA transfer. Each event sets a sticky bit in a status word. A bit stays set until software writes a one to the matching bit of a separate clear word. A separate enable-set word arms each source. The single interrupt output is high while any armed source is pending.

When a bus error arrives and no earlier bus error is still pending, the block captures the faulting 64-bit bus address. Software reads it as two words at the bottom of the register window: the low half at word 0 and the high half at word 1. Registers are reached over a simple word-addressed bus. A write takes one clock edge. Read data is combinational from the address.

Top module: `stor_irq_regs`

## Requirements
- R1: After reset, every mapped word reads zero and `irq` is low.
- R2: A high `ev_chan` in a cycle sets status bit 0, and a high `ev_buserr` sets status bit 1. Both bits are readable at word offset 3 from the next cycle. They stay set whether or not the source is enabled.
- R3: A write to word offset 7 clears each status bit whose matching data bit (bit 0 or bit 1) is one. Zero data bits leave the status unchanged.
- R4: An event in the same cycle as a clear of its bit takes priority, so the bit stays set.
- R5: A write to word offset 5 sets each enable bit whose matching data bit is one. Zero data bits have no effect. The enable bits read back at offset 5, and only reset clears them.
- R6: `irq` is high exactly when some status bit is set together with its enable bit.
- R7: On a bus error while status bit 1 is clear, `fault_addr` is captured. Bits 31:0 read at word offset 0 and bits 63:32 at word offset 1.
- R8: Bus errors that arrive while status bit 1 is set leave the captured address unchanged. After bit 1 is cleared, the next bus error captures again.
- R9: Unused bits and unmapped offsets (2, 4, 6) read as zero. Offsets 7 and 3 also read zero except for the status bits at offset 3. Writes to offset 3 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Write strobe for the addressed word |
| bus_addr | input | AW (3) | Word offset |
| bus_wdata | input | DW (32) | Write data |
| bus_rdata | output | DW (32) | Read data for `bus_addr`, combinational |
| ev_chan | input | 1 | Channel interrupt event |
| ev_buserr | input | 1 | Bus error during DMA |
| fault_addr | input | 2*DW (64) | Faulting bus address, sampled with `ev_buserr` |
| irq | output | 1 | Interrupt request |

## Verification
The assertions watch the register state every cycle. They check that:
- every event sets its bit on the next cycle, including when a clear lands on the same edge;
- a clear with no competing event empties its bit;
- a pending bit holds when no clear is written;
- enable bits never fall;
- the captured address stays frozen while a bus error is pending and takes the input value on a fresh capture;
- `irq` stays low with no enable.

Read-side behaviour can only be seen through the bench's scenarios. This covers the word decode, zero fill of unused bits and offsets, and the ignored status-word write. The same holds for the split of the address across two words and for the sequence of capture, refusal, clear and recapture.

// File: rtl/stor_irq_regs.sv
module stor_irq_regs #(
  parameter int AW = 3,
  parameter int DW = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bus_we,
  input  logic [AW-1:0]   bus_addr,
  input  logic [DW-1:0]   bus_wdata,
  output logic [DW-1:0]   bus_rdata,
  input  logic            ev_chan,
  input  logic            ev_buserr,
  input  logic [2*DW-1:0] fault_addr,
  output logic            irq
);
  localparam logic [AW-1:0] OFS_ELO  = AW'(0);
  localparam logic [AW-1:0] OFS_EHI  = AW'(1);
  localparam logic [AW-1:0] OFS_STAT = AW'(3);
  localparam logic [AW-1:0] OFS_ENS  = AW'(5);
  localparam logic [AW-1:0] OFS_CLR  = AW'(7);

  logic [1:0]      stat_q, en_q;
  logic [2*DW-1:0] err_q;

  wire [1:0] ev_vec  = {ev_buserr, ev_chan};
  wire [1:0] clr_vec = (bus_we && bus_addr == OFS_CLR) ? bus_wdata[1:0] : 2'b00;
  wire [1:0] ens_vec = (bus_we && bus_addr == OFS_ENS) ? bus_wdata[1:0] : 2'b00;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stat_q <= '0;
      en_q   <= '0;
      err_q  <= '0;
    end else begin
      stat_q <= (stat_q & ~clr_vec) | ev_vec;
      en_q   <= en_q | ens_vec;
      if (ev_buserr && !stat_q[1])
        err_q <= fault_addr;
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      OFS_ELO:  bus_rdata = err_q[DW-1:0];
      OFS_EHI:  bus_rdata = err_q[2*DW-1:DW];
      OFS_STAT: bus_rdata[1:0] = stat_q;
      OFS_ENS:  bus_rdata[1:0] = en_q;
      default:  bus_rdata = '0;
    endcase
  end

  assign irq = |(stat_q & en_q);
endmodule

module stor_irq_regs_chk #(
  parameter int AW = 3,
  parameter int DW = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            bus_we,
  input logic [AW-1:0]   bus_addr,
  input logic [DW-1:0]   bus_wdata,
  input logic            ev_chan,
  input logic            ev_buserr,
  input logic [2*DW-1:0] fault_addr,
  input logic [1:0]      stat,
  input logic [1:0]      en,
  input logic [2*DW-1:0] err,
  input logic            irq
);
  wire clr_w = bus_we && bus_addr == AW'(7);

  AST_CHAN_SETS: assert property (@(posedge clk) disable iff (!rst_n) ev_chan |=> stat[0]); // R2
  AST_ERR_SETS: assert property (@(posedge clk) disable iff (!rst_n) ev_buserr |=> stat[1]); // R4
  AST_CLR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n) (clr_w && bus_wdata[0] && !ev_chan) |=> !stat[0]); // R3
  AST_PEND_HOLDS: assert property (@(posedge clk) disable iff (!rst_n) (stat[1] && !(clr_w && bus_wdata[1])) |=> stat[1]); // R3
  AST_EN_NEVER_FALLS: assert property (@(posedge clk) disable iff (!rst_n) (en != 2'b00) |=> ((en & $past(en)) == $past(en))); // R5
  AST_NO_EN_QUIET: assert property (@(posedge clk) disable iff (!rst_n) (en == 2'b00) |-> !irq); // R6
  AST_ADDR_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n) (ev_buserr && !stat[1]) |=> (err == $past(fault_addr))); // R7
  AST_ADDR_FROZEN: assert property (@(posedge clk) disable iff (!rst_n) stat[1] |=> $stable(err)); // R8
endmodule

bind stor_irq_regs stor_irq_regs_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .ev_chan(ev_chan), .ev_buserr(ev_buserr),
  .fault_addr(fault_addr), .stat(stat_q), .en(en_q), .err(err_q), .irq(irq)
);

// File: tb/stor_irq_regs_bench.sv
module stor_irq_regs_bench;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        bus_we = 0;
  logic [2:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        ev_chan = 0, ev_buserr = 0;
  logic [63:0] fault_addr = '0;
  logic        irq;
  int          n_chk = 0, n_err = 0;
  bit          done = 0;

  always #5 clk = ~clk;

  stor_irq_regs u_stor_irq_regs (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ev_chan(ev_chan),
    .ev_buserr(ev_buserr), .fault_addr(fault_addr), .irq(irq)
  );

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    @(negedge clk); bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_we = 0; bus_wdata = '0;
  endtask

  task automatic rd(logic [2:0] a, output logic [31:0] d);
    bus_addr = a; #1; d = bus_rdata;
  endtask

  task automatic pulse(logic c, logic e, logic [63:0] fa);
    @(negedge clk); ev_chan = c; ev_buserr = e; fault_addr = fa;
    @(negedge clk); ev_chan = 0; ev_buserr = 0; fault_addr = '0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    foreach (d[i]) if (i < 8) begin rd(3'(i), d); check("R1 word", d, 0); end
    check("R1 irq", 32'(irq), 0);
  endtask

  task automatic t_latch();
    logic [31:0] d;
    pulse(1, 0, '0);
    rd(3, d); check("R2 chan bit", d, 32'h1);
    check("R6 masked irq", 32'(irq), 0);
    pulse(0, 1, 64'h1234_5678_9ABC_DEF0);
    rd(3, d); check("R2 err bit", d, 32'h3);
    rd(0, d); check("R7 addr low", d, 32'h9ABC_DEF0);
    rd(1, d); check("R7 addr high", d, 32'h1234_5678);
  endtask

  task automatic t_enable();
    logic [31:0] d;
    wr(5, 32'h0);
    rd(5, d); check("R5 zero write", d, 0);
    check("R6 irq off", 32'(irq), 0);
    wr(5, 32'h1);
    rd(5, d); check("R5 set bit0", d, 32'h1);
    check("R6 irq on", 32'(irq), 1);
    wr(5, 32'hFFFF_FFFE);
    rd(5, d); check("R9 enable unused bits", d, 32'h3);
    wr(5, 32'h0);
    rd(5, d); check("R5 zero keeps", d, 32'h3);
  endtask

  task automatic t_second_err();
    logic [31:0] d;
    pulse(0, 1, 64'hAAAA_BBBB_CCCC_DDDD);
    rd(0, d); check("R8 low held", d, 32'h9ABC_DEF0);
    rd(1, d); check("R8 high held", d, 32'h1234_5678);
  endtask

  task automatic t_clear();
    logic [31:0] d;
    wr(7, 32'h0);
    rd(3, d); check("R3 zero clear", d, 32'h3);
    wr(7, 32'h2);
    rd(3, d); check("R3 clear bit1", d, 32'h1);
    check("R6 irq bit0", 32'(irq), 1);
    wr(7, 32'h1);
    rd(3, d); check("R3 clear bit0", d, 0);
    check("R6 irq idle", 32'(irq), 0);
    pulse(0, 1, 64'h0BAD_F00D_1357_2468);
    rd(0, d); check("R8 recapture low", d, 32'h1357_2468);
    rd(1, d); check("R8 recapture high", d, 32'h0BAD_F00D);
    wr(7, 32'h3);
    rd(7, d); check("R9 clear word reads zero", d, 0);
  endtask

  task automatic t_race();
    logic [31:0] d;
    pulse(0, 1, 64'h1);
    @(negedge clk); bus_we = 1; bus_addr = 7; bus_wdata = 32'h3; ev_chan = 1;
    @(negedge clk); bus_we = 0; bus_wdata = '0; ev_chan = 0;
    rd(3, d); check("R4 event beats clear", d, 32'h1);
    wr(7, 32'h3);
    rd(3, d); check("R3 both cleared", d, 0);
  endtask

  task automatic t_unmapped();
    logic [31:0] d;
    wr(3, 32'h3);
    rd(3, d); check("R9 status write ignored", d, 0);
    check("R9 irq after status write", 32'(irq), 0);
    for (int a = 2; a <= 6; a += 2) begin
      wr(3'(a), 32'hFFFF_FFFF);
      rd(3'(a), d); check("R9 unmapped word", d, 0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_latch();
    t_enable();
    t_second_err();
    t_clear();
    t_race();
    t_unmapped();
    done = 1;
  end

  initial begin
    for (int i = 0; i < 20000 && !done; i++) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: got hang expected completion");
    end
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule